// File: doc/BRIEF.md
# Single-Cycle Byte-Coded Processor Core

This block is a small processor that retires one complete instruction on every rising clock edge while its run enable is high. Within that one cycle the instruction is fetched from a byte-addressed memory, its register operands are read, a single ALU forms the arithmetic result, effective address or stack increment, memory is read or written, and up to two registers, the condition codes and the program counter are updated together.

Instructions are one, two, five or six bytes long. The first byte carries an instruction code in its upper nibble and a function code in its lower nibble. A register byte, when present, names rA in its upper nibble and rB in its lower nibble. A 32-bit little-endian constant may follow. The supported operations are no-op, absolute jump, register-register arithmetic/logic, store of a register to a displaced address, and pop from the stack. Instructions and data share the one memory inside the block. With the core held idle, a byte load port fills that memory. Debug ports read any register and any memory word.

Top module: `seq_core`

## Requirements
- R1: While rst_ni is low, the PC, the condition codes (cc_o[2]=zero, cc_o[1]=sign, cc_o[0]=signed overflow) and all eight registers are zero.
- R2: Code 0x0 (no-op) advances the PC by 1 and changes no register, flag or memory byte.
- R3: Code 0x2 (jump, 5 bytes) loads the PC with the little-endian word in the four bytes after the opcode byte.
- R4: Code 0x6 (2 bytes) writes rB op rA into rB and advances the PC by 2. Function 0 is add, 1 is rB minus rA, 2 is AND and 3 is XOR.
- R5: Only code 0x6 updates the condition codes: zero when the result is 0, sign from result bit 31, and signed overflow for add and subtract (always 0 for AND and XOR).
- R6: Code 0x4 (6 bytes: opcode, register byte, 32-bit displacement) writes rA little-endian to address rB plus displacement, changes no register or flag, and advances the PC by 6.
- R7: Code 0xB (2 bytes) loads rA from the word at the current stack pointer (register 4), writes stack pointer plus 4 into register 4 in the same cycle, and advances the PC by 2.
- R8: A pop whose rA is register 4 leaves the loaded word in register 4, not the incremented pointer.
- R9: Any other instruction code advances the PC by 1 and leaves registers, flags and memory unchanged.
- R10: With run_i low no architectural state changes, and each cycle with ld_en_i high writes ld_byte_i to byte ld_addr_i.
- R11: Fetch and data accesses use one memory, so a store into bytes not yet fetched changes the instruction executed there.
- R12: A register field of 8 to 15 (0xF meaning none) reads as zero, and a result aimed at it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Execute one instruction on each rising edge while high |
| ld_en_i | input | 1 | Byte load strobe for memory preload |
| ld_addr_i | input | AW | Byte address for preload |
| ld_byte_i | input | 8 | Preload data byte |
| dbg_reg_sel_i | input | 3 | Register selected for dbg_reg_o |
| dbg_mem_addr_i | input | AW | Byte address of the word on dbg_mem_word_o |
| pc_o | output | 32 | Current program counter |
| cc_o | output | 3 | Condition codes {zero, sign, overflow} |
| dbg_reg_o | output | 32 | Value of the selected register |
| dbg_mem_word_o | output | 32 | Little-endian word at dbg_mem_addr_i |

## Verification
The bench targets signed overflow at the edge of the positive range and on subtraction across signs. A core that mixed up the operand order of subtract, or computed overflow from unsigned carry, would show wrong flags there. A pop into the stack pointer itself is run to catch a write port priority that keeps the incremented pointer instead of the loaded word. A store that overwrites a no-op that has not yet been fetched must turn it into a jump, which exposes any fetch path that reads a stale copy of memory. The bench also feeds the none register field and an unknown opcode, where a careless decoder would write a register or move the PC by the wrong length.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;
  localparam logic [3:0] IC_NOP   = 4'h0;
  localparam logic [3:0] IC_JMP   = 4'h2;
  localparam logic [3:0] IC_STORE = 4'h4;
  localparam logic [3:0] IC_OP    = 4'h6;
  localparam logic [3:0] IC_POP   = 4'hB;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_AND = 2'd2;
  localparam logic [1:0] FN_XOR = 2'd3;

  localparam logic [3:0] REG_NONE = 4'hF;
  localparam logic [3:0] REG_SP   = 4'h4;

  localparam int FETCH_BYTES = 6;
  localparam int WORD_W      = 32;

  typedef enum logic [1:0] {
    ASRC_REG_A,
    ASRC_CONST,
    ASRC_FOUR
  } alu_src_e;

  typedef struct packed {
    logic [3:0]        icode;
    logic [1:0]        alu_fn;
    logic [3:0]        ra;
    logic [3:0]        rb;
    logic [WORD_W-1:0] valc;
    logic [2:0]        len;
  } instr_t;

  typedef struct packed {
    logic [3:0] src_a;
    logic [3:0] src_b;
    logic [3:0] dst_e;
    logic [3:0] dst_m;
    alu_src_e   alu_src;
    logic [1:0] alu_fn;
    logic       mem_wr;
    logic       addr_from_a;
    logic       cc_we;
    logic       jump;
  } ctrl_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_core_pkg::*;
(
  input  logic [8*FETCH_BYTES-1:0] fetch_bytes_i,
  output instr_t                   instr_o,
  output ctrl_t                    ctrl_o
);
  logic [7:0] byte_q [FETCH_BYTES];

  for (genvar k = 0; k < FETCH_BYTES; k++) begin : g_bytes
    assign byte_q[k] = fetch_bytes_i[8*k +: 8];
  end

  always_comb begin
    instr_o.icode  = byte_q[0][7:4];
    instr_o.alu_fn = byte_q[0][1:0];
    instr_o.ra     = byte_q[1][7:4];
    instr_o.rb     = byte_q[1][3:0];
    instr_o.valc   = '0;
    instr_o.len    = 3'd1;

    ctrl_o.src_a       = REG_NONE;
    ctrl_o.src_b       = REG_NONE;
    ctrl_o.dst_e       = REG_NONE;
    ctrl_o.dst_m       = REG_NONE;
    ctrl_o.alu_src     = ASRC_REG_A;
    ctrl_o.alu_fn      = FN_ADD;
    ctrl_o.mem_wr      = 1'b0;
    ctrl_o.addr_from_a = 1'b0;
    ctrl_o.cc_we       = 1'b0;
    ctrl_o.jump        = 1'b0;

    unique case (instr_o.icode)
      IC_JMP: begin
        instr_o.valc = {byte_q[4], byte_q[3], byte_q[2], byte_q[1]};
        instr_o.len  = 3'd5;
        ctrl_o.jump  = 1'b1;
      end
      IC_STORE: begin
        instr_o.valc   = {byte_q[5], byte_q[4], byte_q[3], byte_q[2]};
        instr_o.len    = 3'd6;
        ctrl_o.src_a   = instr_o.ra;
        ctrl_o.src_b   = instr_o.rb;
        ctrl_o.alu_src = ASRC_CONST;
        ctrl_o.mem_wr  = 1'b1;
      end
      IC_OP: begin
        instr_o.len   = 3'd2;
        ctrl_o.src_a  = instr_o.ra;
        ctrl_o.src_b  = instr_o.rb;
        ctrl_o.dst_e  = instr_o.rb;
        ctrl_o.alu_fn = instr_o.alu_fn;
        ctrl_o.cc_we  = 1'b1;
      end
      IC_POP: begin
        instr_o.len        = 3'd2;
        ctrl_o.src_a       = REG_SP;
        ctrl_o.src_b       = REG_SP;
        ctrl_o.dst_e       = REG_SP;
        ctrl_o.dst_m       = instr_o.ra;
        ctrl_o.alu_src     = ASRC_FOUR;
        ctrl_o.addr_from_a = 1'b1;
      end
      default: ;  // no-op and unknown codes: length 1, no effects
    endcase
  end
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_core_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic         zf_o,
  output logic         sf_o,
  output logic         of_o
);
  always_comb begin
    of_o = 1'b0;
    unique case (fn_i)
      FN_ADD: begin
        res_o = b_i + a_i;
        of_o  = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != b_i[W-1]);
      end
      FN_SUB: begin
        res_o = b_i - a_i;
        of_o  = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != b_i[W-1]);
      end
      FN_AND:  res_o = b_i & a_i;
      default: res_o = b_i ^ a_i;
    endcase
    zf_o = (res_o == '0);
    sf_o = res_o[W-1];
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_core_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int NREGS = 8,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    src_a_i,
  input  logic [3:0]    src_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [3:0]    dst_e_i,
  input  logic [W-1:0]  wd_e_i,
  input  logic [3:0]    dst_m_i,
  input  logic [W-1:0]  wd_m_i,
  input  logic [RW-1:0] dbg_sel_i,
  output logic [W-1:0]  dbg_o
);
  logic [W-1:0] regs_q [NREGS];

  function automatic logic hits(logic [3:0] f, int idx);
    return (32'(f) == idx);
  endfunction

  assign rd_a_o = (32'(src_a_i) < NREGS) ? regs_q[src_a_i[RW-1:0]] : '0;
  assign rd_b_o = (32'(src_b_i) < NREGS) ? regs_q[src_b_i[RW-1:0]] : '0;
  assign dbg_o  = regs_q[dbg_sel_i];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_q[i] <= '0;
      else if (we_i && hits(dst_m_i, i))   regs_q[i] <= wd_m_i;  // memory port wins
      else if (we_i && hits(dst_e_i, i))   regs_q[i] <= wd_e_i;
    end
  end

  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dst_m_i == dst_e_i && 32'(dst_m_i) < NREGS)
      |=> regs_q[$past(dst_m_i[RW-1:0])] == $past(wd_m_i));

  assert_none_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && 32'(dst_e_i) >= NREGS && 32'(dst_m_i) >= NREGS)
      |=> regs_q[0] == $past(regs_q[0]));
endmodule

// File: rtl/seq_mem.sv
module seq_mem
  import seq_core_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic                     clk_i,
  input  logic [WORD_W-1:0]        fetch_addr_i,
  output logic [8*FETCH_BYTES-1:0] fetch_bytes_o,
  input  logic [WORD_W-1:0]        data_addr_i,
  output logic [WORD_W-1:0]        rd_data_o,
  input  logic                     wr_en_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic                     ld_en_i,
  input  logic [AW-1:0]            ld_addr_i,
  input  logic [7:0]               ld_byte_i,
  input  logic [AW-1:0]            dbg_addr_i,
  output logic [WORD_W-1:0]        dbg_word_o
);
  localparam int WB = WORD_W / 8;

  logic [7:0] mem_q [MEM_BYTES];

  // addresses wrap modulo MEM_BYTES
  for (genvar k = 0; k < FETCH_BYTES; k++) begin : g_fetch
    logic [AW-1:0] idx;
    assign idx = AW'(fetch_addr_i + 32'(k));
    assign fetch_bytes_o[8*k +: 8] = mem_q[idx];
  end

  for (genvar k = 0; k < WB; k++) begin : g_data
    logic [AW-1:0] rd_idx;
    logic [AW-1:0] dbg_idx;
    assign rd_idx  = AW'(data_addr_i + 32'(k));
    assign dbg_idx = AW'(dbg_addr_i + AW'(k));
    assign rd_data_o[8*k +: 8]  = mem_q[rd_idx];
    assign dbg_word_o[8*k +: 8] = mem_q[dbg_idx];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int k = 0; k < WB; k++) mem_q[AW'(data_addr_i + 32'(k))] <= wr_data_i[8*k +: 8];
    end
    if (ld_en_i) mem_q[ld_addr_i] <= ld_byte_i;
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_core_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ld_en_i,
  input  logic [AW-1:0]     ld_addr_i,
  input  logic [7:0]        ld_byte_i,
  input  logic [2:0]        dbg_reg_sel_i,
  input  logic [AW-1:0]     dbg_mem_addr_i,
  output logic [WORD_W-1:0] pc_o,
  output logic [2:0]        cc_o,
  output logic [WORD_W-1:0] dbg_reg_o,
  output logic [WORD_W-1:0] dbg_mem_word_o
);
  logic [WORD_W-1:0]        pc_q, pc_d;
  logic [2:0]               cc_q;
  logic [8*FETCH_BYTES-1:0] fetch_bytes;
  instr_t                   instr;
  ctrl_t                    ctrl;
  logic [WORD_W-1:0]        val_a, val_b, val_e, val_m, alu_a, data_addr;
  logic                     zf, sf, of;

  seq_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk_i        (clk_i),
    .fetch_addr_i (pc_q),
    .fetch_bytes_o(fetch_bytes),
    .data_addr_i  (data_addr),
    .rd_data_o    (val_m),
    .wr_en_i      (run_i && ctrl.mem_wr),
    .wr_data_i    (val_a),
    .ld_en_i      (ld_en_i),
    .ld_addr_i    (ld_addr_i),
    .ld_byte_i    (ld_byte_i),
    .dbg_addr_i   (dbg_mem_addr_i),
    .dbg_word_o   (dbg_mem_word_o)
  );

  seq_decode u_dec (
    .fetch_bytes_i(fetch_bytes),
    .instr_o      (instr),
    .ctrl_o       (ctrl)
  );

  seq_regfile #(.W(WORD_W), .NREGS(8)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_a_i  (ctrl.src_a),
    .src_b_i  (ctrl.src_b),
    .rd_a_o   (val_a),
    .rd_b_o   (val_b),
    .we_i     (run_i),
    .dst_e_i  (ctrl.dst_e),
    .wd_e_i   (val_e),
    .dst_m_i  (ctrl.dst_m),
    .wd_m_i   (val_m),
    .dbg_sel_i(dbg_reg_sel_i),
    .dbg_o    (dbg_reg_o)
  );

  always_comb begin
    unique case (ctrl.alu_src)
      ASRC_CONST: alu_a = instr.valc;
      ASRC_FOUR:  alu_a = WORD_W'(4);
      default:    alu_a = val_a;
    endcase
  end

  seq_alu #(.W(WORD_W)) u_alu (
    .a_i  (alu_a),
    .b_i  (val_b),
    .fn_i (ctrl.alu_fn),
    .res_o(val_e),
    .zf_o (zf),
    .sf_o (sf),
    .of_o (of)
  );

  assign data_addr = ctrl.addr_from_a ? val_a : val_e;
  assign pc_d      = ctrl.jump ? instr.valc : pc_q + WORD_W'(instr.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      cc_q <= '0;
    end else if (run_i) begin
      pc_q <= pc_d;
      if (ctrl.cc_we) cc_q <= {zf, sf, of};
    end
  end

  assign pc_o = pc_q;
  assign cc_o = cc_q;

  logic known_code;
  assign known_code = instr.icode inside {IC_NOP, IC_JMP, IC_STORE, IC_OP, IC_POP};

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q) && $stable(cc_q));

  assert_nop_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && instr.icode == IC_NOP) |=> pc_q == $past(pc_q) + 32'd1);

  assert_store_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && instr.icode == IC_STORE) |=> pc_q == $past(pc_q) + 32'd6 && $stable(cc_q));

  assert_flags_op_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && instr.icode != IC_OP) |=> $stable(cc_q));

  assert_unknown_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !known_code) |=> pc_q == $past(pc_q) + 32'd1);

  assert_pop_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && instr.icode == IC_POP) |=> pc_q == $past(pc_q) + 32'd2);
endmodule

// File: tb/seq_core_tb.sv
`timescale 1ns/1ps
module seq_core_tb_top;
  localparam int MEM_BYTES = 256;
  localparam int AW = $clog2(MEM_BYTES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_byte = '0;
  logic [2:0]    reg_sel = '0;
  logic [AW-1:0] mem_addr = '0;
  logic [31:0]   pc, reg_val, mem_word;
  logic [2:0]    cc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq_core #(.MEM_BYTES(MEM_BYTES)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .run_i         (run),
    .ld_en_i       (ld_en),
    .ld_addr_i     (ld_addr),
    .ld_byte_i     (ld_byte),
    .dbg_reg_sel_i (reg_sel),
    .dbg_mem_addr_i(mem_addr),
    .pc_o          (pc),
    .cc_o          (cc),
    .dbg_reg_o     (reg_val),
    .dbg_mem_word_o(mem_word)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int idx, logic [31:0] exp);
    reg_sel = 3'(idx);
    #0.1;
    chk(req, $sformatf("r%0d", idx), reg_val, exp);
  endtask

  task automatic chk_mem(string req, int addr, logic [31:0] exp);
    mem_addr = AW'(addr);
    #0.1;
    chk(req, $sformatf("mem[0x%02h]", addr), mem_word, exp);
  endtask

  task automatic put(int addr, logic [7:0] b);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(addr); ld_byte = b;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put_word(int addr, logic [31:0] w);
    for (int k = 0; k < 4; k++) put(addr + k, w[8*k +: 8]);
  endtask

  task automatic step(int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    run = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // jump to 0x40, two discarding pops move SP to 8, four pops fill r0..r3
  task automatic seed(logic [31:0] w0, w1, w2, w3, bit check);
    do_reset();
    put(0, 8'h20); put_word(1, 32'h0000_0040);
    put_word(8, w0); put_word(12, w1); put_word(16, w2); put_word(20, w3);
    put(8'h40, 8'hB0); put(8'h41, 8'hFF);
    put(8'h42, 8'hB0); put(8'h43, 8'hFF);
    put(8'h44, 8'hB0); put(8'h45, 8'h0F);
    put(8'h46, 8'hB0); put(8'h47, 8'h1F);
    put(8'h48, 8'hB0); put(8'h49, 8'h2F);
    put(8'h4A, 8'hB0); put(8'h4B, 8'h3F);
    step(1);
    if (check) chk("R3", "pc after jump", pc, 32'h40);
    step(6);
    if (check) begin
      chk_reg("R7", 0, w0); chk_reg("R7", 1, w1);
      chk_reg("R7", 2, w2); chk_reg("R7", 3, w3);
      chk_reg("R7", 4, 32'd24);
      chk("R7", "pc after pops", pc, 32'h4C);
      chk("R5", "cc after pops", 32'(cc), 32'h0);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #0.1;
    chk("R1", "pc in reset", pc, 32'h0);
    chk("R1", "cc in reset", 32'(cc), 32'h0);
    for (int i = 0; i < 8; i++) chk_reg("R1", i, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_jump_pop();
    seed(32'hDEAD_BEEF, 32'h0000_0007, 32'h8000_0001, 32'h0123_4567, 1'b1);
  endtask

  task automatic test_nop();
    seed(32'd5, 32'd7, 32'd9, 32'd11, 1'b0);
    put(8'h4C, 8'h00); put(8'h4D, 8'h00);
    step(1);
    chk("R2", "pc after nop", pc, 32'h4D);
    step(1);
    chk("R2", "pc after 2 nops", pc, 32'h4E);
    chk_reg("R2", 0, 32'd5); chk_reg("R2", 3, 32'd11); chk_reg("R2", 4, 32'd24);
    chk("R2", "cc", 32'(cc), 32'h0);
  endtask

  task automatic test_alu();
    seed(32'd5, 32'd7, 32'h7FFF_FFFF, 32'd1, 1'b0);
    put(8'h4C, 8'h60); put(8'h4D, 8'h01);  // r1 = r1 + r0
    put(8'h4E, 8'h61); put(8'h4F, 8'h01);  // r1 = r1 - r0
    put(8'h50, 8'h60); put(8'h51, 8'h32);  // r2 = r2 + r3
    put(8'h52, 8'h63); put(8'h53, 8'h11);  // r1 = r1 ^ r1
    put(8'h54, 8'h62); put(8'h55, 8'h03);  // r3 = r3 & r0
    put(8'h56, 8'h61); put(8'h57, 8'h23);  // r3 = r3 - r2
    step(1);
    chk_reg("R4", 1, 32'd12); chk("R4", "pc add", pc, 32'h4E);
    chk("R5", "cc add", 32'(cc), 32'b000);
    step(1);
    chk_reg("R4", 1, 32'd7); chk("R5", "cc sub", 32'(cc), 32'b000);
    step(1);
    chk_reg("R4", 2, 32'h8000_0000); chk("R5", "cc add overflow", 32'(cc), 32'b011);
    step(1);
    chk_reg("R4", 1, 32'h0); chk("R5", "cc xor zero", 32'(cc), 32'b100);
    step(1);
    chk_reg("R4", 3, 32'd1); chk("R5", "cc and", 32'(cc), 32'b000);
    step(1);
    chk_reg("R4", 3, 32'h8000_0001); chk("R5", "cc sub overflow", 32'(cc), 32'b011);
    chk("R4", "pc after ops", pc, 32'h58);
    chk_reg("R4", 0, 32'd5);
  endtask

  task automatic test_store();
    seed(32'h1122_3344, 32'h0000_0080, 32'h0000_6020, 32'h0000_0058, 1'b0);
    put(8'h4C, 8'h40); put(8'h4D, 8'h01); put_word(8'h4E, 32'h10);
    put(8'h52, 8'h40); put(8'h53, 8'h23); put_word(8'h54, 32'h0);
    put_word(8'h58, 32'h0); put(8'h5C, 8'h00);
    put(8'h60, 8'h00);
    step(1);
    chk("R6", "pc after store", pc, 32'h52);
    chk_mem("R6", 8'h90, 32'h1122_3344);
    chk_reg("R6", 1, 32'h80); chk_reg("R6", 0, 32'h1122_3344);
    chk("R6", "cc", 32'(cc), 32'h0);
    step(1);
    chk_mem("R11", 8'h58, 32'h0000_6020);
    chk("R11", "pc before patched code", pc, 32'h58);
    step(1);
    chk("R11", "pc after patched jump", pc, 32'h60);
  endtask

  task automatic test_pop_sp();
    seed(32'd1, 32'd2, 32'd3, 32'd4, 1'b0);
    put_word(24, 32'h0000_00A0);
    put_word(8'hA0, 32'hCAFE_F00D);
    put(8'h4C, 8'hB0); put(8'h4D, 8'h4F);
    put(8'h4E, 8'hB0); put(8'h4F, 8'h5F);
    step(1);
    chk_reg("R8", 4, 32'hA0); chk("R8", "pc", pc, 32'h4E);
    step(1);
    chk_reg("R7", 5, 32'hCAFE_F00D); chk_reg("R7", 4, 32'hA4);
    chk("R7", "pc", pc, 32'h50);
  endtask

  task automatic test_unknown();
    seed(32'd5, 32'd7, 32'd9, 32'd11, 1'b0);
    put(8'h4C, 8'hC5); put(8'h4D, 8'h12);
    put_word(8'h4E, 32'h0);
    step(1);
    chk("R9", "pc after unknown", pc, 32'h4D);
    for (int i = 0; i < 4; i++) chk_reg("R9", i, 32'd5 + 32'(2 * i));
    chk_reg("R9", 4, 32'd24);
    chk("R9", "cc", 32'(cc), 32'h0);
    chk_mem("R9", 8'h4E, 32'h0);
  endtask

  task automatic test_idle();
    seed(32'd5, 32'd7, 32'd9, 32'd11, 1'b0);
    put(8'h4C, 8'h60); put(8'h4D, 8'h01);
    repeat (5) @(negedge clk);
    put_word(8'hF0, 32'hA1B2_C3D4);
    chk("R10", "pc held", pc, 32'h4C);
    chk_reg("R10", 1, 32'd7);
    chk_mem("R10", 8'hF0, 32'hA1B2_C3D4);
  endtask

  task automatic test_none_reg();
    seed(32'd5, 32'd7, 32'd9, 32'd11, 1'b0);
    put(8'h4C, 8'h61); put(8'h4D, 8'hF1);  // r1 = r1 - none
    put(8'h4E, 8'h60); put(8'h4F, 8'h0F);  // result to none
    put(8'h50, 8'h60); put(8'h51, 8'h09);  // rB 9 out of range
    step(1);
    chk_reg("R12", 1, 32'd7);
    step(2);
    for (int i = 0; i < 4; i++) chk_reg("R12", i, 32'd5 + 32'(2 * i));
    chk_reg("R12", 4, 32'd24);
    chk("R12", "pc", pc, 32'h52);
  endtask

  initial begin
    test_reset();
    test_jump_pop();
    test_nop();
    test_alu();
    test_store();
    test_pop_sp();
    test_unknown();
    test_idle();
    test_none_reg();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule